// File: doc/BRIEF.md
# Three-lane 7:1 display link serializer

This block takes one 21-bit pixel word per pixel clock and sends it as three serial data lanes. A fourth lane carries a forwarded clock. The word is made of 18 colour bits (six each of red, green and blue) and three control bits: horizontal sync, vertical sync and data enable. The word is sampled on the falling edge of the pixel clock. It is shifted out during the next pixel period as seven bit slots per lane, one slot per cycle of a bit clock. The bit clock is supplied from outside. It runs at seven times the pixel rate, and its rising edges line up with both edges of the pixel clock.

The pads are driven by the lane outputs and by one output-enable line. The pads go high-impedance while the enable is low. The enable stays low during reset and while the active-low power-down input is held low. After either one is released, the enable stays low until a lock-wait counter has counted a programmable number of pixel clocks. This counter stands in for the settling time of an external clock multiplier. The enable always rises at a frame boundary, so the first frame that is driven is a complete one.

Top module: `ser7_link_tx`

## Requirements
- R1: The value on the pixel inputs at the falling pixel-clock edge is the value that is sent. Input changes made at any other point in the period have no effect on the frame.
- R2: The pixel word is packed as bits 0-5 red[5:0], bits 6-11 green[5:0], bits 12-17 blue[5:0], bit 18 hsync, bit 19 vsync and bit 20 de. Lane k carries word bits 7k to 7k+6. So lane 0 carries red[5:0] then green[0]; lane 1 carries green[5:1] then blue[1:0]; lane 2 carries blue[5:2], hsync, vsync, de.
- R3: In each lane, slot s carries the lane's bit s. Slot 0 is sent first, starting at the rising pixel-clock edge. Each slot lasts one bit-clock cycle.
- R4: The clock lane sends slots 0 to 6 as 1,1,0,0,0,1,1 in every enabled pixel period.
- R5: A word captured at the falling edge in one pixel period is sent whole during the following pixel period. Each pixel period carries exactly one word, and consecutive words are never mixed within a frame.
- R6: While rst_n is low or pd_n is low, out_en is 0 and every lane output is 0.
- R7: Driving pd_n low forces out_en and all lane outputs to 0 at once, without waiting for any clock edge.
- R8: After rst_n and pd_n are both high, out_en stays 0 for at least LOCK_CYCLES falling pixel-clock edges. It then rises at the start of slot 0 of a frame and stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk | input | 1 | Pixel clock; the word is sampled on its falling edge |
| bit_clk | input | 1 | Bit clock, 7x pix_clk, rising edges aligned to pix_clk edges |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down |
| px_red | input | 6 | Red colour bits |
| px_green | input | 6 | Green colour bits |
| px_blue | input | 6 | Blue colour bits |
| px_hsync | input | 1 | Horizontal sync |
| px_vsync | input | 1 | Vertical sync |
| px_de | input | 1 | Data enable |
| data_lane | output | 3 | Serial data lanes 2..0 |
| clk_lane | output | 1 | Forwarded clock lane |
| out_en | output | 1 | Pad output enable; 0 means high-impedance |

## Verification
The assertions assume that exactly seven bit-clock cycles fit in one pixel period. They also assume that both pixel-clock edges fall on bit-clock rising edges, so the toggle seen in the bit domain always arrives one cycle before slot 0. The bench derives both clocks from one timebase: the pixel clock is high for four bit periods and low for three. Pixel inputs change 1 ns after each pixel-clock edge. After every falling edge, the bench drives the inverse of the intended word, so that a capture on the wrong edge would show up. Power-down is asserted between bit-clock edges so that the check for an immediate disable sees no clock edge.

// File: rtl/ser7_pkg.sv
package ser7_pkg;
  localparam int SLOTS   = 7;
  localparam int DLANES  = 3;
  localparam int CLANES  = DLANES + 1;
  localparam int COLOR_W = 6;
  localparam int WORD_W  = SLOTS * DLANES;
  localparam int SLOT_W  = $clog2(SLOTS);

  typedef logic [SLOTS-1:0]  frame_t;
  typedef logic [WORD_W-1:0] word_t;

  // slot s of the forwarded clock is bit s
  localparam frame_t CLK_PAT = 7'b1100011;
endpackage

// File: rtl/ser7_pix_side.sv
module ser7_pix_side
  import ser7_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic  pix_clk,
  input  logic  arst_n,
  input  word_t word_i,
  output word_t word_o,
  output logic  tog_o,
  output logic  lock_o
);
  localparam int CNT_W = $clog2(LOCK_CYCLES + 1);

  logic rs1_q, srst_n;
  always_ff @(negedge pix_clk or negedge arst_n) begin
    if (!arst_n) begin
      rs1_q  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      srst_n <= rs1_q;
    end
  end

  word_t            cap_q;
  logic             tog_q, lock_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             lock_d, cnt_en;

  always_comb begin
    cnt_en = !lock_q;
    cnt_d  = cnt_q;
    lock_d = lock_q;
    if (cnt_en) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(LOCK_CYCLES - 1)) lock_d = 1'b1;
    end
  end

  always_ff @(negedge pix_clk or negedge srst_n) begin
    if (!srst_n) begin
      cap_q  <= '0;
      tog_q  <= 1'b0;
      cnt_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      cap_q  <= word_i;
      tog_q  <= !tog_q;
      cnt_q  <= cnt_d;
      lock_q <= lock_d;
    end
  end

  assign word_o = cap_q;
  assign tog_o  = tog_q;
  assign lock_o = lock_q;

  // R8
  lock_sticky_chk: assert property (@(negedge pix_clk) disable iff (!srst_n)
    lock_q |=> lock_q);
  // R8
  lock_cnt_range_chk: assert property (@(negedge pix_clk) disable iff (!srst_n)
    (!lock_q) |-> (cnt_q < CNT_W'(LOCK_CYCLES)));
endmodule

// File: rtl/ser7_lane.sv
module ser7_lane
  import ser7_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load,
  input  frame_t ld_val,
  output logic   bit_o
);
  frame_t sh_q, sh_d;

  always_comb begin
    if (load) sh_d = ld_val;
    else      sh_d = {1'b0, sh_q[SLOTS-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/ser7_bit_side.sv
module ser7_bit_side
  import ser7_pkg::*;
(
  input  logic              bit_clk,
  input  logic              arst_n,
  input  word_t             word_i,
  input  logic              tog_i,
  input  logic              lock_i,
  output logic [CLANES-1:0] lane_o,
  output logic              oe_o
);
  logic rs1_q, srst_n;
  always_ff @(posedge bit_clk or negedge arst_n) begin
    if (!arst_n) begin
      rs1_q  <= 1'b0;
      srst_n <= 1'b0;
    end else begin
      rs1_q  <= 1'b1;
      srst_n <= rs1_q;
    end
  end

  logic [2:0]        tog_q;
  logic [1:0]        lk_q;
  word_t             hs1_q, hs2_q;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              framed_q, framed_d, oe_q, oe_d, load;
  logic [CLANES-1:0] raw;

  assign load = tog_q[1] ^ tog_q[2];

  always_comb begin
    framed_d = framed_q;
    oe_d     = oe_q;
    if (slot_q == SLOT_W'(SLOTS - 1)) slot_d = '0;
    else                              slot_d = slot_q + 1'b1;
    if (load) begin
      slot_d   = '0;
      framed_d = 1'b1;
      oe_d     = lk_q[1];
    end
  end

  always_ff @(posedge bit_clk or negedge srst_n) begin
    if (!srst_n) begin
      tog_q    <= '0;
      lk_q     <= '0;
      hs1_q    <= '0;
      hs2_q    <= '0;
      slot_q   <= '0;
      framed_q <= 1'b0;
      oe_q     <= 1'b0;
    end else begin
      tog_q    <= {tog_q[1:0], tog_i};
      lk_q     <= {lk_q[0], lock_i};
      hs1_q    <= word_i;
      hs2_q    <= hs1_q;
      slot_q   <= slot_d;
      framed_q <= framed_d;
      oe_q     <= oe_d;
    end
  end

  genvar i;
  for (i = 0; i < CLANES; i++) begin : g_lane
    frame_t ld;
    if (i < DLANES) begin : g_data
      assign ld = hs2_q[i*SLOTS +: SLOTS];
    end else begin : g_clk
      assign ld = CLK_PAT;
    end
    ser7_lane u_lane (
      .clk    (bit_clk),
      .rst_n  (srst_n),
      .load   (load),
      .ld_val (ld),
      .bit_o  (raw[i])
    );
    assign lane_o[i] = raw[i] & oe_q;
  end

  assign oe_o = oe_q;

  // R5
  slot_align_chk: assert property (@(posedge bit_clk) disable iff (!srst_n)
    (framed_q && load) |-> (slot_q == SLOT_W'(SLOTS - 1)));
  // R8
  oe_boundary_chk: assert property (@(posedge bit_clk) disable iff (!srst_n)
    $rose(oe_q) |-> (slot_q == '0));
  // R4
  clk_hi_chk: assert property (@(posedge bit_clk) disable iff (!srst_n)
    (framed_q && slot_q == '0) |-> raw[DLANES]);
  // R4
  clk_lo_chk: assert property (@(posedge bit_clk) disable iff (!srst_n)
    (framed_q && slot_q == SLOT_W'(3)) |-> !raw[DLANES]);
endmodule

// File: rtl/ser7_link_tx.sv
module ser7_link_tx
  import ser7_pkg::*;
#(
  parameter int LOCK_CYCLES = 1024
) (
  input  logic               pix_clk,
  input  logic               bit_clk,
  input  logic               rst_n,
  input  logic               pd_n,
  input  logic [COLOR_W-1:0] px_red,
  input  logic [COLOR_W-1:0] px_green,
  input  logic [COLOR_W-1:0] px_blue,
  input  logic               px_hsync,
  input  logic               px_vsync,
  input  logic               px_de,
  output logic [DLANES-1:0]  data_lane,
  output logic               clk_lane,
  output logic               out_en
);
  logic              arst_n, tog, lock;
  word_t             word_in, word_cap;
  logic [CLANES-1:0] lanes;

  assign arst_n  = rst_n & pd_n;
  assign word_in = {px_de, px_vsync, px_hsync, px_blue, px_green, px_red};

  ser7_pix_side #(.LOCK_CYCLES(LOCK_CYCLES)) u_pix (
    .pix_clk (pix_clk),
    .arst_n  (arst_n),
    .word_i  (word_in),
    .word_o  (word_cap),
    .tog_o   (tog),
    .lock_o  (lock)
  );

  ser7_bit_side u_bit (
    .bit_clk (bit_clk),
    .arst_n  (arst_n),
    .word_i  (word_cap),
    .tog_i   (tog),
    .lock_i  (lock),
    .lane_o  (lanes),
    .oe_o    (out_en)
  );

  assign data_lane = lanes[DLANES-1:0];
  assign clk_lane  = lanes[DLANES];
endmodule

// File: tb/ser7_link_tx_test.sv
`timescale 1ns/100ps
module ser7_link_tx_test;
  localparam int LOCK = 12;

  logic pix_clk, bit_clk, rst_n, pd_n;
  logic [5:0] px_red, px_green, px_blue;
  logic px_hsync, px_vsync, px_de;
  logic [2:0] data_lane;
  logic clk_lane, out_en;

  int unsigned n_pass = 0, n_total = 0, frames = 0;
  int mode = 0;
  logic [20:0] exp_q[$];

  ser7_link_tx #(.LOCK_CYCLES(LOCK)) uut (
    .pix_clk(pix_clk), .bit_clk(bit_clk), .rst_n(rst_n), .pd_n(pd_n),
    .px_red(px_red), .px_green(px_green), .px_blue(px_blue),
    .px_hsync(px_hsync), .px_vsync(px_vsync), .px_de(px_de),
    .data_lane(data_lane), .clk_lane(clk_lane), .out_en(out_en));

  initial begin
    bit_clk = 1'b0;
    forever #2.5 bit_clk = ~bit_clk;
  end
  initial begin
    pix_clk = 1'b0;
    #2.5;
    forever begin
      pix_clk = 1'b1; #20;
      pix_clk = 1'b0; #15;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_total++;
    if (ok) n_pass++;
    else $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_pass, n_total);
    $finish;
  endtask

  function automatic logic [20:0] gen(input int n, input int m);
    case (m)
      0: gen = 21'(n * 37 + 5);
      1: gen = 21'(1) << (n % 21);
      2: gen = n[0] ? 21'h155555 : 21'h0AAAAA;
      default: gen = n[0] ? 21'h1FFFFF : 21'h000000;
    endcase
  endfunction

  task automatic apply(input logic [20:0] w);
    {px_de, px_vsync, px_hsync, px_blue, px_green, px_red} = w;
  endtask

  // driver: intended word after the rising edge, its inverse after the falling edge (R1)
  initial begin : drv
    int n;
    logic [20:0] w;
    n = 0;
    apply('0);
    forever begin
      @(posedge pix_clk);
      #1;
      w = gen(n, mode);
      apply(w);
      exp_q.push_back(w);
      n++;
      @(negedge pix_clk);
      #1;
      apply(~w);
    end
  end

  // monitor: frames start at the enable rise, one slot per bit clock
  initial begin : mon
    logic [20:0] got, w;
    logic [6:0] gclk;
    int s;
    bit run;
    run = 0;
    s = 0;
    got = '0;
    gclk = '0;
    forever begin
      @(negedge bit_clk);
      if (!out_en) run = 0;
      else begin
        if (!run) begin
          run = 1;
          s = 0;
          while (exp_q.size() > 2) void'(exp_q.pop_front());
        end
        for (int k = 0; k < 3; k++) got[k*7 + s] = data_lane[k];
        gclk[s] = clk_lane;
        if (s == 6) begin
          s = 0;
          if (exp_q.size() == 0) chk(0, "R5", "no word pending", 32'(got), 0);
          else begin
            w = exp_q.pop_front();
            chk(got == w, "R1 R2 R3 R5", "frame word", 32'(got), 32'(w));
            chk(gclk == 7'b1100011, "R4", "clock lane frame", 32'(gclk), 32'h63);
            frames++;
          end
        end else s++;
      end
    end
  end

  task automatic measure_lock;
    int cnt;
    cnt = 0;
    while (!out_en) begin
      @(negedge pix_clk);
      cnt++;
    end
    chk(cnt >= LOCK + 1 && cnt <= LOCK + 4, "R8", "pixel edges until enable",
        32'(cnt), 32'(LOCK + 3));
  endtask

  initial begin : wdog
    #(200000 * 5.0);
    n_total++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : main
    int f0;
    rst_n = 1'b0;
    pd_n  = 1'b1;
    repeat (3) @(posedge pix_clk);
    #3;
    chk(out_en == 1'b0, "R6", "enable in reset", 32'(out_en), 0);
    chk({data_lane, clk_lane} == 4'b0, "R6", "lanes in reset", 32'({data_lane, clk_lane}), 0);
    @(posedge pix_clk);
    #1;
    rst_n = 1'b1;
    measure_lock();
    for (int m = 0; m < 4; m++) begin
      @(posedge pix_clk);
      mode = m;
      repeat (15) @(posedge pix_clk);
    end
    chk(frames >= 55, "R5", "frames sent", 32'(frames), 55);

    @(posedge bit_clk);
    #1.2;
    pd_n = 1'b0;
    #0.5;
    chk(out_en == 1'b0, "R7", "enable right after power-down", 32'(out_en), 0);
    chk({data_lane, clk_lane} == 4'b0, "R7", "lanes right after power-down",
        32'({data_lane, clk_lane}), 0);
    repeat (5) @(negedge pix_clk);
    #2;
    chk(out_en == 1'b0, "R6", "enable in power-down", 32'(out_en), 0);
    chk({data_lane, clk_lane} == 4'b0, "R6", "lanes in power-down",
        32'({data_lane, clk_lane}), 0);
    @(posedge pix_clk);
    #1;
    mode = 0;
    f0 = frames;
    pd_n = 1'b1;
    measure_lock();
    repeat (12) @(posedge pix_clk);
    chk(frames >= f0 + 10, "R5", "frames after power-down release",
        32'(frames), 32'(f0 + 10));
    finish_run();
  end
endmodule